// File: doc/BRIEF.md
# Multi-Master System Bus Arbiter

This block sits beside one local processor and wins or gives up a shared system bus for it. It watches the processor's three-bit bus status. The code 3'b111 means the processor is idle. Any other code means a bus cycle is in progress. When the processor starts a cycle that needs the system bus, the arbiter raises its bus request. When it holds the priority grant and no other master is driving the busy line, it takes ownership. It then drives busy and enables the local address path.

The arbiter keeps the bus after a cycle ends. It gives the bus up only at a moment when the processor is idle. How eagerly it does so is set by strapping inputs:
- A resident-bus strap lets a select input decide which cycles need the system bus at all.
- An any-request strap makes a common bus request from another master release the bus at the end of the current cycle.
- Without that strap, a common bus request is honoured only after the processor has stayed idle for a while.

Two active-low lock inputs block surrender. One blocks it completely. The other blocks only surrender to requests that arrive on the common request line. All decisions are taken on the rising edge of the processor-side clock. An active-low asynchronous reset puts the arbiter in the not-holding state.

Top module: `mm_bus_arbiter`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no activity, `bus_req_no`, `busy_no`, `aen_no`, `creq_no` are all 1.
- R2: `status_i` = 3'b111 is idle, and any other value is a bus cycle. When a system cycle is present at a clock edge while the arbiter neither requests nor holds, `bus_req_no` is 0 after that edge.
- R3: With `resident_strap_i` = 1, a cycle requests the bus only if `sys_sel_i` = 1. With `resident_strap_i` = 0, `sys_sel_i` has no effect and every cycle requests.
- R4: While requesting, the arbiter takes the bus at an edge where `prio_in_ni` = 0 and `busy_ni` = 1. After that edge, `busy_no` = 0 and `aen_no` = 0. They are never 0 before that.
- R5: `creq_no` is 0 exactly while the arbiter requests without holding and `prio_in_ni` = 1.
- R6: `prio_out_no` is 0 exactly while the arbiter neither requests nor holds and `prio_in_ni` = 0.
- R7: While holding with `lock_ni` = 1, an idle edge with `prio_in_ni` = 1 surrenders. After that edge, `bus_req_no`, `busy_no` and `aen_no` are all 1.
- R8: While `lock_ni` = 0, a held bus is never surrendered.
- R9: While `creq_lock_ni` = 0, `creq_ni` = 0 causes no surrender, but loss of priority (R7) still does.
- R10: With `any_req_strap_i` = 1, `creq_ni` = 0 surrenders at the first idle edge.
- R11: With `any_req_strap_i` = 0, `creq_ni` = 0 surrenders only at an idle edge that is at least the QUIET_CYCLES-th consecutive idle edge (default 2).
- R12: With `any_req_strap_i` = 1 and `creq_ni` held 0, the bus is given up after every transfer cycle.
- R13: A held bus is never surrendered at an edge where `status_i` is not 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor-side clock; all decisions are taken on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 3 | Processor bus status; 3'b111 means idle |
| sys_sel_i | input | 1 | 1 selects the system bus for the current cycle |
| resident_strap_i | input | 1 | Strap: qualify requests with `sys_sel_i` |
| any_req_strap_i | input | 1 | Strap: release on a common request at the end of the cycle |
| lock_ni | input | 1 | Full surrender lock, active low |
| creq_lock_ni | input | 1 | Common-request surrender lock, active low |
| prio_in_ni | input | 1 | Priority grant from the resolver, active low |
| busy_ni | input | 1 | Shared busy line as observed, active low |
| creq_ni | input | 1 | Shared common request line as observed, active low |
| bus_req_no | output | 1 | Bus request to the priority resolver, active low |
| prio_out_no | output | 1 | Grant passed down to the next lower priority master, active low |
| busy_no | output | 1 | Drive onto the shared busy line, active low |
| creq_no | output | 1 | Drive onto the common request line, active low |
| aen_no | output | 1 | Local address enable, active low |

## Verification
If the arbiter holds the wrong ownership state, the handshake outputs show it one clock after the edge that took the wrong decision. A missed surrender leaves `busy_no` low at an idle edge where it should have risen. A wrong grab drops `aen_no` without a grant. The idle-run counter only shows its effect when a common request meets a run of idle edges, so the stimulus mixes short and long idle gaps under both strap settings. The lock inputs are held during surrender conditions to show that `busy_no` stays low.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_HOLD = 2'd2
  } arb_state_e;

  localparam logic [2:0] STATUS_PASSIVE = 3'b111;
endpackage

// File: rtl/arb_status_decode.sv
module arb_status_decode #(
  parameter int QUIET_CYCLES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] status_i,
  input  logic       resident_strap_i,
  input  logic       sys_sel_i,
  output logic       passive_o,
  output logic       sys_need_o,
  output logic       quiet_o
);
  import arb_pkg::*;

  localparam int RUN_W = $clog2(QUIET_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(QUIET_CYCLES);
  localparam logic [RUN_W-1:0] QUIET_M1 = RUN_W'(QUIET_CYCLES - 1);

  logic [RUN_W-1:0] run_q;

  assign passive_o  = (status_i == STATUS_PASSIVE);
  assign sys_need_o = !passive_o && (resident_strap_i ? sys_sel_i : 1'b1);
  // run_q counts idle edges already seen; this edge makes one more
  assign quiet_o    = passive_o && (run_q >= QUIET_M1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (!passive_o) run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/arb_surrender_policy.sv
module arb_surrender_policy (
  input  logic passive_i,
  input  logic quiet_i,
  input  logic lock_ni,
  input  logic creq_lock_ni,
  input  logic any_req_strap_i,
  input  logic prio_in_ni,
  input  logic creq_ni,
  output logic release_o
);
  logic lost_prio;
  logic common_ok;

  assign lost_prio = prio_in_ni;
  assign common_ok = !creq_ni && creq_lock_ni && (any_req_strap_i || quiet_i);
  assign release_o = passive_i && lock_ni && (lost_prio || common_ok);
endmodule

// File: rtl/arb_handshake.sv
module arb_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_need_i,
  input  logic release_i,
  input  logic prio_in_ni,
  input  logic busy_ni,
  output logic bus_req_no,
  output logic prio_out_no,
  output logic busy_no,
  output logic creq_no,
  output logic aen_no
);
  import arb_pkg::*;

  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (sys_need_i) state_d = ST_REQ;
      ST_REQ:  if (!prio_in_ni && busy_ni) state_d = ST_HOLD;
      ST_HOLD: if (release_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign bus_req_no  = (state_q == ST_IDLE);
  assign busy_no     = (state_q != ST_HOLD);
  assign aen_no      = (state_q != ST_HOLD);
  assign creq_no     = !((state_q == ST_REQ) && prio_in_ni);
  assign prio_out_no = !((state_q == ST_IDLE) && !prio_in_ni);
endmodule

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter #(
  parameter int QUIET_CYCLES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] status_i,
  input  logic       sys_sel_i,
  input  logic       resident_strap_i,
  input  logic       any_req_strap_i,
  input  logic       lock_ni,
  input  logic       creq_lock_ni,
  input  logic       prio_in_ni,
  input  logic       busy_ni,
  input  logic       creq_ni,
  output logic       bus_req_no,
  output logic       prio_out_no,
  output logic       busy_no,
  output logic       creq_no,
  output logic       aen_no
);
  logic passive, sys_need, quiet, release_now;

  arb_status_decode #(.QUIET_CYCLES(QUIET_CYCLES)) u_decode (
    .clk_i, .rst_ni, .status_i, .resident_strap_i, .sys_sel_i,
    .passive_o(passive), .sys_need_o(sys_need), .quiet_o(quiet)
  );

  arb_surrender_policy u_policy (
    .passive_i(passive), .quiet_i(quiet), .lock_ni, .creq_lock_ni,
    .any_req_strap_i, .prio_in_ni, .creq_ni, .release_o(release_now)
  );

  arb_handshake u_hs (
    .clk_i, .rst_ni, .sys_need_i(sys_need), .release_i(release_now),
    .prio_in_ni, .busy_ni, .bus_req_no, .prio_out_no, .busy_no,
    .creq_no, .aen_no
  );
endmodule

// File: rtl/mm_bus_arbiter_chk.sv
module mm_bus_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] status_i,
  input logic       lock_ni,
  input logic       prio_in_ni,
  input logic       busy_ni,
  input logic       bus_req_no,
  input logic       busy_no,
  input logic       creq_no,
  input logic       aen_no
);
  a_r4_aen_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(aen_no) |-> ($past(prio_in_ni) == 1'b0) && $past(busy_ni) && !$past(bus_req_no));

  a_r7_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_no) |-> aen_no && bus_req_no && $past(status_i) == 3'b111);

  a_r8_lock_keeps_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && !lock_ni) |=> !busy_no);

  a_r13_no_midcycle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && status_i != 3'b111) |=> !busy_no);

  a_r5_creq_only_when_requesting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !creq_no |-> !bus_req_no && busy_no && prio_in_ni);
endmodule

bind mm_bus_arbiter mm_bus_arbiter_chk u_chk (
  .clk_i, .rst_ni, .status_i, .lock_ni, .prio_in_ni, .busy_ni,
  .bus_req_no, .busy_no, .creq_no, .aen_no
);

// File: tb/mm_bus_arbiter_tb.sv
`timescale 1ns/1ps
module mm_bus_arbiter_tb;
  localparam int QUIET = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] status = 3'b111;
  logic sys_sel = 1'b1, res_strap = 1'b0, any_strap = 1'b0;
  logic lock_n = 1'b1, clock_n = 1'b1, prio_n = 1'b1, busy_n = 1'b1, creq_n = 1'b1;
  logic bus_req_no, prio_out_no, busy_no, creq_no, aen_no;

  int n_chk = 0, n_bad = 0;
  int m_st = 0;   // 0 idle, 1 requesting, 2 holding
  int m_run = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mm_bus_arbiter #(.QUIET_CYCLES(QUIET)) u_dut (
    .clk_i(clk), .rst_ni, .status_i(status), .sys_sel_i(sys_sel),
    .resident_strap_i(res_strap), .any_req_strap_i(any_strap),
    .lock_ni(lock_n), .creq_lock_ni(clock_n), .prio_in_ni(prio_n),
    .busy_ni(busy_n), .creq_ni(creq_n), .bus_req_no, .prio_out_no,
    .busy_no, .creq_no, .aen_no
  );

  function automatic int next_state(int st, int run);
    bit idle = (status == 3'b111);
    bit need = !idle && (res_strap ? sys_sel : 1'b1);
    bit quiet = idle && (run >= QUIET - 1);
    bit rel = idle && lock_n && (prio_n || (!creq_n && clock_n && (any_strap || quiet)));
    case (st)
      0: return need ? 1 : 0;
      1: return (!prio_n && busy_n) ? 2 : 1;
      default: return rel ? 0 : 2;
    endcase
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "bus_req_no", bus_req_no, m_st == 0);
    check(tag, "busy_no", busy_no, m_st != 2);
    check(tag, "aen_no", aen_no, m_st != 2);
    check(tag, "creq_no", creq_no, !(m_st == 1 && prio_n));
    check(tag, "prio_out_no", prio_out_no, !(m_st == 0 && !prio_n));
  endtask

  task automatic step(string tag);
    int nst;
    nst = next_state(m_st, m_run);
    @(posedge clk);
    m_st = nst;
    m_run = (status == 3'b111) ? ((m_run < QUIET) ? m_run + 1 : m_run) : 0;
    #2;
    check_all(tag);
    @(negedge clk);
  endtask

  // take the bus: one cycle of status, grant given, busy free
  task automatic acquire(string tag);
    status = 3'b100; prio_n = 1'b0; busy_n = 1'b1; creq_n = 1'b1;
    step(tag); step(tag);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #3;
    check_all("R1");        // in reset
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    step("R1");

    // R2 / R4: request then acquire
    status = 3'b001; prio_n = 1'b1; step("R2");
    check("R2", "bus_req_no", bus_req_no, 1'b0);
    check("R5", "creq_no", creq_no, 1'b0);
    busy_n = 1'b0; prio_n = 1'b0; step("R4");
    check("R4", "aen_no", aen_no, 1'b1);
    busy_n = 1'b1; step("R4");
    check("R4", "aen_no", aen_no, 1'b0);
    // R13: priority lost mid-cycle, no release
    prio_n = 1'b1; step("R13");
    check("R13", "busy_no", busy_no, 1'b0);
    // R8: idle with lock
    status = 3'b111; lock_n = 1'b0; step("R8");
    check("R8", "busy_no", busy_no, 1'b0);
    lock_n = 1'b1; step("R7");
    check("R7", "busy_no", busy_no, 1'b1);
    check("R6", "prio_out_no", prio_out_no, 1'b1);
    prio_n = 1'b0; #1;
    check("R6", "prio_out_no", prio_out_no, 1'b0);

    // R3: resident strap
    res_strap = 1'b1; sys_sel = 1'b0; status = 3'b010; step("R3");
    check("R3", "bus_req_no", bus_req_no, 1'b1);
    status = 3'b111; step("R3");
    res_strap = 1'b0; status = 3'b010; step("R3");
    check("R3", "bus_req_no", bus_req_no, 1'b0);
    busy_n = 1'b1; step("R3");
    sys_sel = 1'b1;

    // R9: common request locked
    status = 3'b111; creq_n = 1'b0; clock_n = 1'b0; any_strap = 1'b1;
    step("R9"); step("R9");
    check("R9", "busy_no", busy_no, 1'b0);
    prio_n = 1'b1; step("R9");
    check("R9", "busy_no", busy_no, 1'b1);
    clock_n = 1'b1;

    // R10: any-request releases at first idle edge
    acquire("R10");
    status = 3'b111; creq_n = 1'b0; step("R10");
    check("R10", "busy_no", busy_no, 1'b1);

    // R11: without strap needs QUIET consecutive idle edges
    any_strap = 1'b0;
    acquire("R11");
    creq_n = 1'b0; status = 3'b111; step("R11");
    check("R11", "busy_no", busy_no, 1'b0);
    step("R11");
    check("R11", "busy_no", busy_no, 1'b1);

    // R12: forced release after every transfer
    any_strap = 1'b1;
    for (int i = 0; i < 3; i++) begin
      status = 3'b100; prio_n = 1'b0; creq_n = 1'b0;
      step("R12"); step("R12");
      check("R12", "busy_no", busy_no, 1'b0);
      status = 3'b111; step("R12");
      check("R12", "busy_no", busy_no, 1'b1);
    end

    // random mix: R2 R4 R5 R6 R7 R8 R9 R10 R11 R13
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) begin
        res_strap = 1'($urandom_range(0, 1));
        any_strap = 1'($urandom_range(0, 1));
      end
      status  = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 6)) : 3'b111;
      sys_sel = 1'($urandom_range(0, 3) != 0);
      prio_n  = 1'($urandom_range(0, 2) == 0);
      busy_n  = 1'($urandom_range(0, 3) != 0);
      creq_n  = 1'($urandom_range(0, 2) != 0);
      lock_n  = 1'($urandom_range(0, 5) != 0);
      clock_n = 1'($urandom_range(0, 3) != 0);
      step("R2/R4/R5/R6/R7/R8/R9/R10/R11/R13");
    end

    // R1: reset in the middle of ownership
    acquire("R1");
    rst_ni = 1'b0; m_st = 0; m_run = 0; #2;
    check_all("R1");
    @(negedge clk); rst_ni = 1'b1;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule